// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block sits on a two-wire serial control bus as a slave. It lets an outside bus master read and write 16-bit registers in a 15-bit address space. The bus clock and data lines are sampled with the fast system clock. Start and stop conditions are recovered from the sampled lines. A fixed 7-bit device identifier is matched, and every accepted byte is acknowledged. Register accesses leave the block on a simple parallel bus: an address, write data with a one-cycle write strobe, a one-cycle read strobe, and read data that the surrounding logic returns in the same cycle.

A write transfer carries the device identifier with the direction bit clear, two address bytes, then one or more data words, each sent high byte first. A read transfer first writes the address, then issues a repeated start with the direction bit set. The slave then returns words high byte first until the master answers a byte with no acknowledge. With the auto-increment input high, the address steps by one after each word; with it low, every word uses the same address. A write-only input makes the slave refuse read requests. The data line is driven only low or left released, so other devices on the bus can arbitrate.

Top module: `i2c_reg_slave`

## Requirements
- R1: A falling data line while the clock is high is a start; a rising data line while the clock is high is a stop. A start at idle or at a byte boundary begins a device identifier byte. A stop always returns the block to idle, and a later start opens a fresh transfer.
- R2: After a start, eight bits are taken MSB first. The upper seven are the device identifier and bit 0 is the direction (1 = read, 0 = write). When the identifier equals 0x34, the slave pulls the data line low for the ninth clock.
- R3: With a different identifier, or with direction = 1 while write_only is high, the ninth clock is left released. All following bytes are then ignored until a new start.
- R4: The slave only pulls the data line low or releases it, and it changes its drive only while the clock line is low.
- R5: The register address arrives as two bytes, high byte first. Bit 7 of the first byte is discarded, giving a 15-bit address on reg_addr. Both bytes are acknowledged.
- R6: Write data arrives as bytes, high byte first, each one acknowledged. After each low byte, reg_we pulses for one cycle with reg_addr and reg_wdata holding the word.
- R7: A repeated start with direction = 1 returns the word at reg_addr, high byte first, with one reg_re pulse per word loaded. A no-acknowledge from the master ends the transfer, and the line stays released until the stop.
- R8: With auto_inc high, the address increases by one after every word written or read. With auto_inc low, successive words use the same address.
- R9: A start seen in the middle of a byte, or while the slave is sending read data, abandons the transfer to idle. The bits that follow are not acknowledged.
- R10: A stop before a word's low byte is complete causes no register write.
- R11: During and right after reset, the data line is released and neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| write_only | input | 1 | 1 refuses read requests |
| auto_inc | input | 1 | 1 steps the address after each word |
| reg_addr | output | 15 | Register address |
| reg_wdata | output | 16 | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe, data taken the same cycle |
| reg_rdata | input | 16 | Register read data for reg_addr |

## Verification
The bound checker watches properties on every cycle. These are: the drive only changes while the clock line is low; the write strobe lasts one cycle and the address holds steady under it; the read and write strobes never meet; a stop always lands in idle; and idle never pulls the line. The bench's scenarios are needed for everything that depends on whole byte sequences. These cover identifier matching and refusal, the discarded address bit, word assembly and auto-increment order, read data values, abort on a mid-byte start, and the missing write after an early stop. Those results are compared against a behavioural register model in the bench.

// File: rtl/irs_pkg.sv
package irs_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int ID_W   = 7;
    localparam int SLOT_W = 4;
    localparam int HI_W   = ADDR_W - BYTE_W;

    localparam logic [SLOT_W-1:0] SLOT_LAST_BIT = SLOT_W'(BYTE_W - 1);
    localparam logic [SLOT_W-1:0] SLOT_ACK      = SLOT_W'(BYTE_W);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVID,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WR_HI,
        ST_WR_LO,
        ST_RD_HI,
        ST_RD_LO,
        ST_WAIT
    } xfer_st_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic              byte_done;
        logic              ack_rise;
        logic              frame_end;
        logic              boundary;
        logic [BYTE_W-1:0] rx_byte;
        logic              ack_bit;
    } frame_ev_t;

    function automatic logic is_tx(input xfer_st_e s);
        return (s == ST_RD_HI) || (s == ST_RD_LO);
    endfunction

    function automatic logic id_accept(input logic [BYTE_W-1:0] b,
                                       input logic [ID_W-1:0]   id,
                                       input logic              wr_only);
        return (b[BYTE_W-1:1] == id) && !(b[0] && wr_only);
    endfunction

endpackage

// File: rtl/irs_sync.sv
module irs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/irs_bus_events.sv
module irs_bus_events
    import irs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/irs_framer.sv
module irs_framer
    import irs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_ev,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda,
    input  logic              load_tx,
    input  logic [BYTE_W-1:0] tx_byte,
    output frame_ev_t         fe,
    output logic [SLOT_W-1:0] slot,
    output logic              pre,
    output logic              tx_bit
);
    logic [SLOT_W-1:0] slot_q;
    logic              pre_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            pre_q  <= 1'b1;
            rx_q   <= '0;
            tx_q   <= '1;
        end else if (start_ev) begin
            slot_q <= '0;
            pre_q  <= 1'b1;
        end else begin
            if (scl_rise && !pre_q && slot_q < SLOT_ACK)
                rx_q <= {rx_q[BYTE_W-2:0], sda};
            if (scl_fall) begin
                if (pre_q) begin
                    pre_q <= 1'b0;
                end else if (slot_q == SLOT_ACK) begin
                    slot_q <= '0;
                end else begin
                    slot_q <= slot_q + SLOT_W'(1);
                    if (slot_q < SLOT_LAST_BIT)
                        tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
                end
            end
            if (load_tx)
                tx_q <= tx_byte;
        end
    end

    always_comb begin
        fe.byte_done = scl_rise && !pre_q && (slot_q == SLOT_LAST_BIT);
        fe.ack_rise  = scl_rise && !pre_q && (slot_q == SLOT_ACK);
        fe.frame_end = scl_fall && !pre_q && (slot_q == SLOT_ACK);
        fe.boundary  = (slot_q == '0);
        fe.rx_byte   = {rx_q[BYTE_W-2:0], sda};
        fe.ack_bit   = sda;
    end

    assign slot   = slot_q;
    assign pre    = pre_q;
    assign tx_bit = tx_q[BYTE_W-1];
endmodule

// File: rtl/irs_protocol.sv
module irs_protocol
    import irs_pkg::*;
#(
    parameter logic [ID_W-1:0] DEV_ID = 7'h34
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  frame_ev_t         fe,
    input  logic              write_only,
    input  logic              auto_inc,
    input  logic [DATA_W-1:0] reg_rdata,
    output xfer_st_e          state,
    output logic              ack_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    output logic              load_tx,
    output logic [BYTE_W-1:0] tx_byte
);
    xfer_st_e          state_q, nxt_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [HI_W-1:0]   addr_hi_q;
    logic [BYTE_W-1:0] wr_hi_q;
    logic [BYTE_W-1:0] rd_lo_q;
    logic              ack_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic              fetch_word;

    assign load_tx    = fe.frame_end && (state_q != ST_IDLE) &&
                        ((nxt_q == ST_RD_HI) || (nxt_q == ST_RD_LO));
    assign fetch_word = load_tx && (nxt_q == ST_RD_HI);
    assign tx_byte    = (nxt_q == ST_RD_HI) ? reg_rdata[DATA_W-1:BYTE_W] : rd_lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            nxt_q     <= ST_IDLE;
            ptr_q     <= '0;
            addr_hi_q <= '0;
            wr_hi_q   <= '0;
            rd_lo_q   <= '0;
            ack_q     <= 1'b0;
            we_q      <= 1'b0;
            wdata_q   <= '0;
        end else begin
            we_q <= 1'b0;
            if (stop_ev) begin
                state_q <= ST_IDLE;
                ack_q   <= 1'b0;
            end else if (start_ev) begin
                ack_q <= 1'b0;
                if (state_q == ST_IDLE || (fe.boundary && !is_tx(state_q)))
                    state_q <= ST_DEVID;
                else
                    state_q <= ST_IDLE;
            end else if (state_q != ST_IDLE) begin
                if (fe.byte_done) begin
                    unique case (state_q)
                        ST_DEVID: begin
                            if (id_accept(fe.rx_byte, DEV_ID, write_only)) begin
                                ack_q <= 1'b1;
                                nxt_q <= fe.rx_byte[0] ? ST_RD_HI : ST_ADDR_HI;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                        ST_ADDR_HI: begin
                            addr_hi_q <= fe.rx_byte[HI_W-1:0];
                            ack_q     <= 1'b1;
                            nxt_q     <= ST_ADDR_LO;
                        end
                        ST_ADDR_LO: begin
                            ptr_q <= {addr_hi_q, fe.rx_byte};
                            ack_q <= 1'b1;
                            nxt_q <= ST_WR_HI;
                        end
                        ST_WR_HI: begin
                            wr_hi_q <= fe.rx_byte;
                            ack_q   <= 1'b1;
                            nxt_q   <= ST_WR_LO;
                        end
                        ST_WR_LO: begin
                            we_q    <= 1'b1;
                            wdata_q <= {wr_hi_q, fe.rx_byte};
                            ack_q   <= 1'b1;
                            nxt_q   <= ST_WR_HI;
                        end
                        default: ;
                    endcase
                end
                if (fe.ack_rise) begin
                    if (state_q == ST_WR_LO && auto_inc)
                        ptr_q <= ptr_q + ADDR_W'(1);
                    if (state_q == ST_RD_HI)
                        nxt_q <= fe.ack_bit ? ST_WAIT : ST_RD_LO;
                    if (state_q == ST_RD_LO) begin
                        nxt_q <= fe.ack_bit ? ST_WAIT : ST_RD_HI;
                        if (auto_inc)
                            ptr_q <= ptr_q + ADDR_W'(1);
                    end
                end
                if (fe.frame_end) begin
                    state_q <= nxt_q;
                    ack_q   <= 1'b0;
                    if (fetch_word)
                        rd_lo_q <= reg_rdata[BYTE_W-1:0];
                end
            end
        end
    end

    assign state     = state_q;
    assign ack_en    = ack_q;
    assign reg_addr  = ptr_q;
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;
    assign reg_re    = fetch_word;
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import irs_pkg::*;
#(
    parameter logic [ID_W-1:0] DEV_ID      = 7'h34,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_low,
    input  logic              write_only,
    input  logic              auto_inc,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic [1:0]        lines_s;
    bus_ev_t           bus_ev;
    frame_ev_t         fe;
    logic [SLOT_W-1:0] slot;
    logic              pre;
    logic              tx_bit;
    logic              load_tx;
    logic [BYTE_W-1:0] tx_byte;
    logic              ack_en;
    xfer_st_e          st;
    logic              stop_ev;
    logic              drive_q;

    irs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(lines_s)
    );

    irs_bus_events u_events (
        .clk(clk), .rst(rst), .scl_s(lines_s[1]), .sda_s(lines_s[0]), .ev(bus_ev)
    );

    irs_framer u_framer (
        .clk(clk), .rst(rst),
        .start_ev(bus_ev.start), .scl_rise(bus_ev.scl_rise),
        .scl_fall(bus_ev.scl_fall), .sda(bus_ev.sda),
        .load_tx(load_tx), .tx_byte(tx_byte),
        .fe(fe), .slot(slot), .pre(pre), .tx_bit(tx_bit)
    );

    irs_protocol #(.DEV_ID(DEV_ID)) u_proto (
        .clk(clk), .rst(rst),
        .start_ev(bus_ev.start), .stop_ev(bus_ev.stop), .fe(fe),
        .write_only(write_only), .auto_inc(auto_inc), .reg_rdata(reg_rdata),
        .state(st), .ack_en(ack_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .load_tx(load_tx), .tx_byte(tx_byte)
    );

    assign stop_ev = bus_ev.stop;

    always_ff @(posedge clk) begin
        if (rst)
            drive_q <= 1'b0;
        else
            drive_q <= !pre && (((slot == SLOT_ACK) && ack_en) ||
                                (is_tx(st) && (slot < SLOT_ACK) && !tx_bit));
    end

    assign sda_drive_low = drive_q;
endmodule

// File: rtl/irs_checker.sv
module irs_checker
    import irs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_drive_low,
    input logic              reg_we,
    input logic              reg_re,
    input logic [ADDR_W-1:0] reg_addr,
    input xfer_st_e          state,
    input logic              stop_ev
);
    assert_drive_scl_low_R4: assert property (@(posedge clk) disable iff (rst)
        (sda_drive_low != $past(sda_drive_low)) |-> !scl_i);

    assert_we_single_R6: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    assert_we_addr_stable_R6: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $stable(reg_addr));

    assert_strobes_apart_R7: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re));

    assert_stop_to_idle_R1: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> (state == ST_IDLE));

    assert_idle_released_R3: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && ($past(state) == ST_IDLE)) |-> !sda_drive_low);
endmodule

bind i2c_reg_slave irs_checker u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_drive_low(sda_drive_low),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .state(st), .stop_ev(stop_ev)
);

// File: tb/i2c_reg_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_reg_slave_tb_top;
    localparam int HALF = 20;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, scl, m_sda, write_only, auto_inc;
    logic        sda_drive_low, reg_we, reg_re;
    logic [14:0] reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    wire         sda_line;
    logic [15:0] mem     [0:255];
    logic [15:0] ref_mem [0:255];
    logic [30:0] exp_q[$];
    int          n_chk = 0, n_fail = 0, re_cnt = 0;
    bit          run = 1'b0;
    logic        drv_prev = 1'b0;

    assign sda_line  = m_sda & ~sda_drive_low;
    assign reg_rdata = mem[reg_addr[7:0]];

    i2c_reg_slave dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .sda_drive_low(sda_drive_low), .write_only(write_only), .auto_inc(auto_inc),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // reference model: expected write queue compared every clock
    always @(negedge clk) begin
        if (run) begin
            if (sda_drive_low !== drv_prev)
                check(scl == 1'b0, "R4 drive changes only with clock low", scl, 0);
            drv_prev = sda_drive_low;
            if (reg_re) re_cnt++;
            if (reg_we) begin
                if (exp_q.size() == 0) begin
                    check(0, "R10 unexpected register write", {reg_addr, reg_wdata}, 0);
                end else begin
                    logic [30:0] e;
                    e = exp_q.pop_front();
                    check({reg_addr, reg_wdata} == e, "R6 write address and data",
                          {reg_addr, reg_wdata}, e);
                end
                mem[reg_addr[7:0]] = reg_wdata;
            end
        end
    end

    initial begin
        repeat (150000) @(negedge clk);
        check(0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wt(HALF); scl = 1'b1; wt(HALF);
        m_sda = 1'b0; wt(HALF); scl = 1'b0; wt(4);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wt(HALF); scl = 1'b1; wt(HALF);
        m_sda = 1'b1; wt(HALF);
    endtask

    task automatic put_bit(input bit b);
        m_sda = b; wt(HALF); scl = 1'b1; wt(HALF); scl = 1'b0; wt(4);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_sda = 1'b1; wt(HALF); scl = 1'b1; wt(HALF);
        ack = (sda_line == 1'b0);
        scl = 1'b0; wt(4);
    endtask

    task automatic read_byte(output logic [7:0] d, input bit m_ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wt(HALF); scl = 1'b1; wt(HALF);
            d[i] = sda_line;
            scl = 1'b0; wt(4);
        end
        put_bit(!m_ack);
        m_sda = 1'b1;
    endtask

    task automatic wr_txn(input logic [14:0] a, input logic [15:0] w0, input logic [15:0] w1,
                          input int n, input bit ainc, input bit junk, input string req);
        bit ok = 1'b1, ak;
        auto_inc = ainc;
        for (int k = 0; k < n; k++) begin
            logic [14:0] ea;
            logic [15:0] ew;
            ea = ainc ? 15'(a + k) : a;
            ew = (k == 0) ? w0 : w1;
            exp_q.push_back({ea, ew});
            ref_mem[ea[7:0]] = ew;
        end
        i2c_start();
        send_byte(8'h68, ak); ok &= ak;
        send_byte({junk, a[14:8]}, ak); ok &= ak;
        send_byte(a[7:0], ak); ok &= ak;
        for (int k = 0; k < n; k++) begin
            logic [15:0] w;
            w = (k == 0) ? w0 : w1;
            send_byte(w[15:8], ak); ok &= ak;
            send_byte(w[7:0], ak); ok &= ak;
        end
        i2c_stop();
        wt(10);
        check(ok, req, ok, 1);
    endtask

    task automatic rd_txn(input logic [14:0] a, input int n, input bit ainc, input string req);
        bit ok = 1'b1, ak;
        int r0;
        logic [7:0] hi, lo;
        auto_inc = ainc;
        r0 = re_cnt;
        i2c_start();
        send_byte(8'h68, ak); ok &= ak;
        send_byte({1'b0, a[14:8]}, ak); ok &= ak;
        send_byte(a[7:0], ak); ok &= ak;
        i2c_start();
        send_byte(8'h69, ak); ok &= ak;
        for (int k = 0; k < n; k++) begin
            logic [14:0] ea;
            ea = ainc ? 15'(a + k) : a;
            read_byte(hi, 1'b1);
            read_byte(lo, k < n - 1);
            check({hi, lo} == ref_mem[ea[7:0]], req, {hi, lo}, ref_mem[ea[7:0]]);
        end
        wt(10);
        check(sda_drive_low == 1'b0, "R7 line released after master NACK", sda_drive_low, 0);
        i2c_stop();
        wt(10);
        check(ok, "R2 R7 address and read header acknowledged", ok, 1);
        check(re_cnt - r0 == n, "R7 one read strobe per word", re_cnt - r0, n);
    endtask

    initial begin
        bit ak;
        for (int i = 0; i < 256; i++) begin
            mem[i] = '0;
            ref_mem[i] = '0;
        end
        rst = 1'b1; scl = 1'b1; m_sda = 1'b1; write_only = 1'b0; auto_inc = 1'b0;
        wt(5);
        check(!sda_drive_low && !reg_we && !reg_re, "R11 outputs idle in reset",
              {sda_drive_low, reg_we, reg_re}, 0);
        rst = 1'b0;
        wt(5);
        check(!sda_drive_low && !reg_we && !reg_re, "R11 outputs idle after reset",
              {sda_drive_low, reg_we, reg_re}, 0);
        run = 1'b1;

        // R1: bare start then stop, then a normal write
        i2c_start(); i2c_stop(); wt(10);
        wr_txn(15'h0012, 16'hBEEF, 16'h0, 1, 1'b0, 1'b0, "R1 R2 R6 single write acknowledged");
        // R5: top bit of first address byte discarded, full 15-bit address
        wr_txn(15'h5A13, 16'h1234, 16'h0, 1, 1'b0, 1'b1, "R5 address with discarded top bit");
        // R8: auto-increment off then on
        wr_txn(15'h0020, 16'h1111, 16'h2222, 2, 1'b0, 1'b0, "R8 repeated writes same address");
        wr_txn(15'h0030, 16'hA0A0, 16'hB0B1, 2, 1'b1, 1'b0, "R8 writes with address step");

        // R7: reads
        rd_txn(15'h0012, 1, 1'b0, "R7 single read data");
        rd_txn(15'h5A13, 1, 1'b0, "R7 read at 15-bit address");
        rd_txn(15'h0030, 2, 1'b1, "R8 stepped read data");
        rd_txn(15'h0020, 2, 1'b0, "R8 repeated read same address");

        // R3: wrong identifier
        i2c_start();
        send_byte(8'h6A, ak);
        check(!ak, "R3 foreign identifier not acknowledged", ak, 0);
        send_byte(8'h00, ak);
        check(!ak, "R3 bytes ignored until new start", ak, 0);
        i2c_stop(); wt(10);

        // R3: read refused in write-only mode, writes still taken
        write_only = 1'b1;
        i2c_start();
        send_byte(8'h69, ak);
        check(!ak, "R3 read refused in write-only mode", ak, 0);
        i2c_stop(); wt(10);
        wr_txn(15'h0050, 16'h5555, 16'h0, 1, 1'b0, 1'b0, "R3 write accepted in write-only mode");
        write_only = 1'b0;

        // R9: start in the middle of a byte abandons the transfer
        i2c_start();
        send_byte(8'h68, ak);
        check(ak, "R9 identifier acknowledged before abort", ak, 1);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        i2c_start();
        send_byte(8'h68, ak);
        check(!ak, "R9 no acknowledge after mid-byte start", ak, 0);
        i2c_stop(); wt(10);
        wr_txn(15'h0060, 16'hC3C3, 16'h0, 1, 1'b0, 1'b0, "R1 fresh transfer after abort");

        // R10: stop after the high data byte gives no write
        i2c_start();
        send_byte(8'h68, ak);
        send_byte(8'h00, ak);
        send_byte(8'h40, ak);
        send_byte(8'h99, ak);
        i2c_stop(); wt(20);
        rd_txn(15'h0040, 1, 1'b0, "R10 register untouched by partial write");

        wt(50);
        check(exp_q.size() == 0, "R6 every expected write seen", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule